// File: doc/BRIEF.md
# Machine-Level Hardware Performance Monitor

This block keeps the machine-level performance counters of a 32-bit RISC-V core. Two counters are always present: a cycle counter and an instructions-retired counter. Beside them sits a parameterised bank of programmable counters. Each programmable counter has its own event selector, which chooses one of sixteen event lines, holds an overflow flag and holds three privilege-mode inhibit bits. The core drives the event lines with single-cycle pulses and reports its current privilege mode. Software reads and writes every register through a simple CSR port.

Every counter is 64 bits wide and appears as two 32-bit CSR halves. A programmable counter that wraps sets the overflow flag in its selector. If that flag was clear before the wrap, the block raises a one-cycle overflow interrupt request. The core's interrupt-pending logic latches that request.

Top module: `hpm_unit`

## Requirements
- R1: After reset, every counter, every event selector, the inhibit register and `ovf_irq_o` are zero.
- R2: The cycle counter (CSR 0xB00 low, 0xB80 high) adds one on every clock edge. The instructions-retired counter (0xB02 / 0xB82) adds one on each edge where `evt_i[1]` is high. Bits 0 and 2 of the inhibit register respectively freeze them.
- R3: Programmable counter i (CSR 0xB03+i low, 0xB83+i high) has its selector at CSR 0x323+i. Selector bits 7:0 hold an event code. The counter adds one on an edge where `evt_i[code-1]` is high and the code is 1 to 16. A code of 0 or of 17 to 255 never counts.
- R4: Selector bit 30 inhibits counting in machine mode (`priv_i`=3). Bit 29 inhibits counting in supervisor mode (`priv_i`=1). Bit 28 inhibits counting in user mode (`priv_i`=0). While `priv_i`=2 a programmable counter never counts.
- R5: Bit 3+i of the inhibit register (CSR 0x320) freezes programmable counter i. Only bits 0, 2 and 3 to 2+NUM_PROG can be written. All other bits read zero.
- R6: A write to the low half of a counter replaces bits 31:0 and leaves bits 63:32 unchanged. A write to the high half replaces bits 63:32 and leaves bits 31:0 unchanged.
- R7: When a CSR write to a counter coincides with an increment of that counter, the written value is stored and the increment is dropped.
- R8: When a programmable counter steps from all ones to zero, selector bit 31 (the overflow flag) becomes 1. The flag stays set until software writes it.
- R9: A wrap with the overflow flag clear raises `ovf_irq_o` for exactly one cycle, from the same edge at which the counter becomes zero. A wrap with the flag already set raises nothing. The fixed counters never raise it.
- R10: `csr_rdata_o` returns the addressed register combinationally. A selector reads back only bits 31:28 and 7:0, with its other bits zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_we_i | input | 1 | CSR write strobe |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` |
| evt_i | input | NUM_EVT | Event pulses; bit k is event code k+1 |
| priv_i | input | 2 | Current privilege mode of the core |
| cycle_o | output | 64 | Cycle counter value |
| instret_o | output | 64 | Instructions-retired counter value |
| hpm_cnt_o | output | 64*NUM_PROG | Programmable counter values, counter 0 in the low bits |
| ovf_irq_o | output | 1 | Overflow interrupt request pulse |

## Verification
The bench builds the block with NUM_PROG=3 and the default sixteen events. This keeps the inhibit register small enough that its whole writable mask can be checked in one readback. It also leaves an unused counter running next to a frozen one.

With this configuration the bench sweeps every event code from 0 to 20, plus 255, against a walking pattern of single-bit event pulses. It also sweeps all eight inhibit-bit combinations in each of the four privilege modes. Overflow is reached by preloading a counter near all ones through its two halves. This covers the first wrap, a repeated wrap with the flag still set, and a wrap after software clears the flag.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

   localparam int XLEN_DEF = 32;
   localparam int CODE_W   = 8;

   // CSR addresses (machine-level counter space)
   localparam logic [11:0] A_CYCLE_LO   = 12'hB00;
   localparam logic [11:0] A_CYCLE_HI   = 12'hB80;
   localparam logic [11:0] A_INSTRET_LO = 12'hB02;
   localparam logic [11:0] A_INSTRET_HI = 12'hB82;
   localparam logic [11:0] A_HPM_LO     = 12'hB03;
   localparam logic [11:0] A_HPM_HI     = 12'hB83;
   localparam logic [11:0] A_EVSEL      = 12'h323;
   localparam logic [11:0] A_INHIBIT    = 12'h320;

   // selector bit positions
   localparam int SEL_OF   = 31;
   localparam int SEL_MINH = 30;
   localparam int SEL_SINH = 29;
   localparam int SEL_UINH = 28;

   // privilege encodings
   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   // event codes; code k is carried on evt_i[k-1]
   typedef enum logic [CODE_W-1:0] {
      EV_NONE        = 8'd0,
      EV_CYCLES      = 8'd1,
      EV_INSTRET     = 8'd2,
      EV_BRANCH      = 8'd3,
      EV_MISPRED     = 8'd4,
      EV_FE_STALL    = 8'd5,
      EV_BE_STALL    = 8'd6,
      EV_DC_RD       = 8'd7,
      EV_DC_RD_MISS  = 8'd8,
      EV_DC_WR       = 8'd9,
      EV_DC_WR_MISS  = 8'd10,
      EV_IC_RD       = 8'd11,
      EV_IC_RD_MISS  = 8'd12,
      EV_DTLB_RD     = 8'd13,
      EV_DTLB_MISS   = 8'd14,
      EV_ITLB_RD     = 8'd15,
      EV_ITLB_MISS   = 8'd16
   } hpm_evt_e;

   localparam int NUM_EVT_DEF = 16;

endpackage

// File: rtl/hpm_counter.sv
module hpm_counter #(
   parameter int W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [W/2-1:0]   wdata,
   output logic [W-1:0]     q,
   output logic             wrap
);
   localparam int HW = W / 2;

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_w
         $error("hpm_counter: W must be even and at least 4");
      end
   endgenerate

   logic any_wr;
   assign any_wr = wr_lo | wr_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (any_wr) begin
         if (wr_lo) q[HW-1:0] <= wdata;
         if (wr_hi) q[W-1:HW] <= wdata;
      end else if (inc) begin
         q <= q + 1'b1;
      end
   end

   assign wrap = inc & ~any_wr & (&q);

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !any_wr) |=> (q == $past(q) + 1'b1));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !any_wr) |=> $stable(q));

   assert_half_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (q[W-1:HW] == $past(q[W-1:HW])));

   assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (q[HW-1:0] == $past(wdata)));

endmodule

// File: rtl/hpm_evsel.sv
module hpm_evsel
   import hpm_pkg::*;
#(
   parameter int NUM_EVT = 16,
   parameter int XLEN    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [XLEN-1:0]    wdata,
   input  logic [NUM_EVT-1:0] evt,
   input  logic [1:0]         priv,
   input  logic               frz,
   input  logic               wrap,
   output logic [XLEN-1:0]    sel_o,
   output logic               inc,
   output logic               irq
);
   generate
      if (XLEN <= SEL_OF) begin : g_bad_xlen
         $error("hpm_evsel: XLEN too small for selector layout");
      end
      if (NUM_EVT < 1 || NUM_EVT > 255) begin : g_bad_evt
         $error("hpm_evsel: NUM_EVT out of range");
      end
   endgenerate

   logic              of_q;
   logic [2:0]        inh_q;   // {M,S,U}
   logic [CODE_W-1:0] code_q;
   logic              irq_q;
   logic              hit;
   logic              mode_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         of_q   <= 1'b0;
         inh_q  <= '0;
         code_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr) begin
            of_q   <= wdata[SEL_OF];
            inh_q  <= {wdata[SEL_MINH], wdata[SEL_SINH], wdata[SEL_UINH]};
            code_q <= wdata[CODE_W-1:0];
         end else if (wrap) begin
            of_q <= 1'b1;
         end
         irq_q <= wrap & ~of_q;
      end
   end

   always_comb begin
      hit = 1'b0;
      for (int k = 1; k <= NUM_EVT; k++) begin
         if (code_q == CODE_W'(k)) hit = evt[k-1];
      end
   end

   always_comb begin
      case (priv)
         PRIV_M:  mode_blk = inh_q[2];
         PRIV_S:  mode_blk = inh_q[1];
         PRIV_U:  mode_blk = inh_q[0];
         default: mode_blk = 1'b1;
      endcase
   end

   assign inc = hit & ~mode_blk & ~frz;
   assign irq = irq_q;

   always_comb begin
      sel_o                = '0;
      sel_o[SEL_OF]        = of_q;
      sel_o[SEL_MINH]      = inh_q[2];
      sel_o[SEL_SINH]      = inh_q[1];
      sel_o[SEL_UINH]      = inh_q[0];
      sel_o[CODE_W-1:0]    = code_q;
   end

   assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (code_q != '0 && code_q <= CODE_W'(NUM_EVT)));

   assert_mode_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> ((priv == PRIV_M && !sel_o[SEL_MINH]) ||
               (priv == PRIV_S && !sel_o[SEL_SINH]) ||
               (priv == PRIV_U && !sel_o[SEL_UINH])));

   assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frz |-> !inc);

   assert_of_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !wr) |=> sel_o[SEL_OF]);

   assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   assert_irq_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(of_q) && !$past(wr)) |-> irq_q);

endmodule

// File: rtl/hpm_unit.sv
module hpm_unit
   import hpm_pkg::*;
#(
   parameter int NUM_PROG = 4,
   parameter int NUM_EVT  = 16,
   parameter int XLEN     = 32,
   parameter int CNT_W    = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [11:0]               csr_addr_i,
   input  logic [XLEN-1:0]           csr_wdata_i,
   input  logic                      csr_we_i,
   output logic [XLEN-1:0]           csr_rdata_o,
   input  logic [NUM_EVT-1:0]        evt_i,
   input  logic [1:0]                priv_i,
   output logic [CNT_W-1:0]          cycle_o,
   output logic [CNT_W-1:0]          instret_o,
   output logic [CNT_W*NUM_PROG-1:0] hpm_cnt_o,
   output logic                      ovf_irq_o
);
   localparam int INH_W = NUM_PROG + 3;
   localparam logic [INH_W-1:0] INH_MASK = ~(INH_W'(2));
   localparam int HW = CNT_W / 2;

   generate
      if (NUM_PROG < 1 || NUM_PROG > 29) begin : g_bad_prog
         $error("hpm_unit: NUM_PROG must be 1..29");
      end
      if (CNT_W != 2 * XLEN) begin : g_bad_cnt
         $error("hpm_unit: CNT_W must be twice XLEN");
      end
      if (NUM_EVT < 2) begin : g_bad_evt
         $error("hpm_unit: NUM_EVT must include the retire event");
      end
   endgenerate

   logic [INH_W-1:0] cinh_q;
   logic             wr_inh;
   logic [1:0]       fix_wrap;

   assign wr_inh = csr_we_i && (csr_addr_i == A_INHIBIT);

   always_ff @(posedge clk) begin
      if (!rst_n)      cinh_q <= '0;
      else if (wr_inh) cinh_q <= csr_wdata_i[INH_W-1:0] & INH_MASK;
   end

   // fixed counters
   logic wr_cyc_lo, wr_cyc_hi, wr_ir_lo, wr_ir_hi;
   assign wr_cyc_lo = csr_we_i && (csr_addr_i == A_CYCLE_LO);
   assign wr_cyc_hi = csr_we_i && (csr_addr_i == A_CYCLE_HI);
   assign wr_ir_lo  = csr_we_i && (csr_addr_i == A_INSTRET_LO);
   assign wr_ir_hi  = csr_we_i && (csr_addr_i == A_INSTRET_HI);

   hpm_counter #(.W(CNT_W)) u_cycle (
      .clk(clk), .rst_n(rst_n), .inc(~cinh_q[0]),
      .wr_lo(wr_cyc_lo), .wr_hi(wr_cyc_hi), .wdata(csr_wdata_i),
      .q(cycle_o), .wrap(fix_wrap[0]));

   hpm_counter #(.W(CNT_W)) u_instret (
      .clk(clk), .rst_n(rst_n), .inc(evt_i[EV_INSTRET-1] & ~cinh_q[2]),
      .wr_lo(wr_ir_lo), .wr_hi(wr_ir_hi), .wdata(csr_wdata_i),
      .q(instret_o), .wrap(fix_wrap[1]));

   // programmable counters
   logic [CNT_W-1:0] cnt   [NUM_PROG];
   logic [XLEN-1:0]  sel   [NUM_PROG];
   logic [NUM_PROG-1:0] prog_inc, prog_wrap, prog_irq;

   generate
      for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
         logic wr_lo, wr_hi, wr_sel;
         assign wr_lo  = csr_we_i && (csr_addr_i == 12'(A_HPM_LO + 12'(i)));
         assign wr_hi  = csr_we_i && (csr_addr_i == 12'(A_HPM_HI + 12'(i)));
         assign wr_sel = csr_we_i && (csr_addr_i == 12'(A_EVSEL + 12'(i)));

         hpm_evsel #(.NUM_EVT(NUM_EVT), .XLEN(XLEN)) u_sel (
            .clk(clk), .rst_n(rst_n), .wr(wr_sel), .wdata(csr_wdata_i),
            .evt(evt_i), .priv(priv_i), .frz(cinh_q[3+i]),
            .wrap(prog_wrap[i]), .sel_o(sel[i]), .inc(prog_inc[i]),
            .irq(prog_irq[i]));

         hpm_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(prog_inc[i]),
            .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(csr_wdata_i),
            .q(cnt[i]), .wrap(prog_wrap[i]));

         assign hpm_cnt_o[i*CNT_W +: CNT_W] = cnt[i];
      end
   endgenerate

   assign ovf_irq_o = |prog_irq;

   // read mux
   always_comb begin
      csr_rdata_o = '0;
      case (csr_addr_i)
         A_CYCLE_LO:   csr_rdata_o = cycle_o[HW-1:0];
         A_CYCLE_HI:   csr_rdata_o = cycle_o[CNT_W-1:HW];
         A_INSTRET_LO: csr_rdata_o = instret_o[HW-1:0];
         A_INSTRET_HI: csr_rdata_o = instret_o[CNT_W-1:HW];
         A_INHIBIT:    csr_rdata_o = XLEN'(cinh_q);
         default:      csr_rdata_o = '0;
      endcase
      for (int i = 0; i < NUM_PROG; i++) begin
         if (csr_addr_i == 12'(A_HPM_LO + 12'(i))) csr_rdata_o = cnt[i][HW-1:0];
         if (csr_addr_i == 12'(A_HPM_HI + 12'(i))) csr_rdata_o = cnt[i][CNT_W-1:HW];
         if (csr_addr_i == 12'(A_EVSEL + 12'(i)))  csr_rdata_o = sel[i];
      end
   end

   assert_cycle_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cinh_q[0] && !wr_cyc_lo && !wr_cyc_hi) |=> $stable(cycle_o));

   assert_cycle_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cinh_q[0] && !wr_cyc_lo && !wr_cyc_hi) |=> (cycle_o == $past(cycle_o) + 1'b1));

   assert_fixed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((|fix_wrap) && !(|prog_wrap)) |=> !ovf_irq_o);

   assert_inhibit_bit1_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inh |=> (cinh_q[1] == 1'b0));

endmodule

// File: tb/tb_hpm_unit.sv
`timescale 1ns/1ps
module tb_hpm_unit;
   import hpm_pkg::*;

   localparam int NP = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [11:0]       csr_addr_i = '0;
   logic [31:0]       csr_wdata_i = '0;
   logic              csr_we_i = 1'b0;
   logic [31:0]       csr_rdata_o;
   logic [15:0]       evt_i = '0;
   logic [1:0]        priv_i = 2'd3;
   logic [63:0]       cycle_o, instret_o;
   logic [64*NP-1:0]  hpm_cnt_o;
   logic              ovf_irq_o;

   int tests = 0;
   int fails = 0;
   int irqn  = 0;

   hpm_unit #(.NUM_PROG(NP)) dut (
      .clk(clk), .rst_n(rst_n), .csr_addr_i(csr_addr_i),
      .csr_wdata_i(csr_wdata_i), .csr_we_i(csr_we_i),
      .csr_rdata_o(csr_rdata_o), .evt_i(evt_i), .priv_i(priv_i),
      .cycle_o(cycle_o), .instret_o(instret_o), .hpm_cnt_o(hpm_cnt_o),
      .ovf_irq_o(ovf_irq_o));

   always #5 clk = ~clk;

   always @(negedge clk) if (rst_n && ovf_irq_o) irqn++;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1;
      @(negedge clk);
      csr_we_i = 1'b0;
   endtask

   task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
      csr_addr_i = a;
      #1;
      d = csr_rdata_o;
   endtask

   function automatic logic [63:0] cnt(input int i);
      return hpm_cnt_o[i*64 +: 64];
   endfunction

   task automatic overflow_run(output int delta);
      int base;
      evt_i = '0;
      csr_wr(A_HPM_HI, 32'hFFFF_FFFF);
      csr_wr(A_HPM_LO, 32'hFFFF_FFFD);
      base = irqn;
      @(negedge clk); evt_i = 16'h0001;
      repeat (3) @(negedge clk);
      evt_i = '0;
      repeat (2) @(negedge clk);
      delta = irqn - base;
   endtask

   initial begin
      #1_000_000;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] rd, rd2;
      logic [63:0] s1, s2;
      int exp_n, d;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 cycle in reset", cycle_o, 64'd0);
      rst_n = 1'b1;
      chk("R1 instret", instret_o, 64'd0);
      chk("R1 prog counters", {64'd0, hpm_cnt_o[63:0] | hpm_cnt_o[127:64] | hpm_cnt_o[191:128]}, 128'd0);
      chk("R1 irq", {63'd0, ovf_irq_o}, 64'd0);
      csr_rd(A_EVSEL, rd);   chk("R1 selector", {32'd0, rd}, 64'd0);
      csr_rd(A_INHIBIT, rd); chk("R1 inhibit", {32'd0, rd}, 64'd0);

      // R2 cycle counter
      csr_wr(A_CYCLE_HI, 32'd0);
      csr_wr(A_CYCLE_LO, 32'd0);
      repeat (10) @(negedge clk);
      chk("R2 cycle runs", cycle_o, 64'd10);
      csr_wr(A_INHIBIT, 32'h1);
      s1 = cycle_o;
      repeat (5) @(negedge clk);
      chk("R2 cycle frozen", cycle_o, s1);
      csr_wr(A_INHIBIT, 32'h0);

      // R2 instret counter
      csr_wr(A_INSTRET_LO, 32'd0);
      exp_n = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         evt_i = (k % 3 == 0) ? 16'h0002 : 16'h0000;
         if (k % 3 == 0) exp_n++;
      end
      @(negedge clk); evt_i = '0;
      @(negedge clk);
      chk("R2 instret pulses", instret_o, 64'(exp_n));
      csr_wr(A_INHIBIT, 32'h4);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); evt_i = 16'h0002;
      end
      @(negedge clk); evt_i = '0;
      @(negedge clk);
      chk("R2 instret frozen", instret_o, 64'(exp_n));
      csr_wr(A_INHIBIT, 32'h0);

      // R3 event code sweep on counter 0
      for (int code = 0; code <= 21; code++) begin
         logic [7:0] c;
         c = (code == 21) ? 8'd255 : 8'(code);
         csr_wr(A_EVSEL, {24'd0, c});
         csr_wr(A_HPM_LO, 32'd0);
         csr_wr(A_HPM_HI, 32'd0);
         for (int b = 0; b < 16; b++) begin
            @(negedge clk); evt_i = 16'(1 << b);
         end
         @(negedge clk); evt_i = 16'hFFFF;
         repeat (3) @(negedge clk);
         evt_i = '0;
         @(negedge clk);
         chk($sformatf("R3 code %0d", c), cnt(0),
             (c >= 8'd1 && c <= 8'd16) ? 64'd4 : 64'd0);
      end

      // R4 privilege-mode inhibit sweep
      for (int p = 0; p < 4; p++) begin
         for (int inh = 0; inh < 8; inh++) begin
            logic blk;
            logic [2:0] ib;
            ib = 3'(inh);
            case (p)
               3: blk = ib[2];
               1: blk = ib[1];
               0: blk = ib[0];
               default: blk = 1'b1;
            endcase
            csr_wr(A_EVSEL, {1'b0, ib, 20'd0, 8'd1});
            csr_wr(A_HPM_LO, 32'd0);
            @(negedge clk); priv_i = 2'(p); evt_i = 16'h0001;
            repeat (5) @(negedge clk);
            evt_i = '0;
            @(negedge clk);
            chk($sformatf("R4 priv %0d inh %0d", p, inh), cnt(0), blk ? 64'd0 : 64'd5);
         end
      end
      priv_i = 2'd3;

      // R5 per-counter freeze
      csr_wr(A_EVSEL + 12'd1, 32'd1);
      csr_wr(A_EVSEL + 12'd2, 32'd1);
      csr_wr(A_HPM_LO + 12'd1, 32'd0);
      csr_wr(A_HPM_LO + 12'd2, 32'd0);
      @(negedge clk); evt_i = 16'h0001;
      repeat (4) @(negedge clk);
      csr_wr(A_INHIBIT, 32'h10);
      s1 = cnt(1); s2 = cnt(2);
      repeat (5) @(negedge clk);
      chk("R5 counter1 frozen", cnt(1), s1);
      chk("R5 counter2 runs", cnt(2), s2 + 64'd5);
      evt_i = '0;
      csr_wr(A_INHIBIT, 32'hFFFF_FFFF);
      csr_rd(A_INHIBIT, rd);
      chk("R5 inhibit mask", {32'd0, rd}, 64'h3D);
      csr_wr(A_INHIBIT, 32'h0);

      // R6 half writes
      csr_wr(A_EVSEL + 12'd2, 32'd0);
      csr_wr(A_HPM_HI + 12'd2, 32'hA5A5_A5A5);
      csr_wr(A_HPM_LO + 12'd2, 32'h1234_5678);
      chk("R6 full load", cnt(2), 64'hA5A5_A5A5_1234_5678);
      csr_wr(A_HPM_LO + 12'd2, 32'd0);
      chk("R6 low write keeps high", cnt(2), 64'hA5A5_A5A5_0000_0000);
      csr_wr(A_HPM_HI + 12'd2, 32'd1);
      chk("R6 high write keeps low", cnt(2), 64'h0000_0001_0000_0000);

      // R7 write beats increment
      csr_wr(A_EVSEL, 32'd1);
      csr_wr(A_HPM_HI, 32'd0);
      @(negedge clk); evt_i = 16'h0001;
      repeat (2) @(negedge clk);
      csr_wr(A_HPM_LO, 32'd100);
      chk("R7 written value kept", cnt(0), 64'd100);
      repeat (3) @(negedge clk);
      chk("R7 counting resumes", cnt(0), 64'd103);
      evt_i = '0;

      // R8 / R9 overflow
      csr_wr(A_EVSEL, 32'd1);
      overflow_run(d);
      chk("R8 wrapped to zero", cnt(0), 64'd0);
      csr_rd(A_EVSEL, rd);
      chk("R8 overflow flag set", {63'd0, rd[31]}, 64'd1);
      chk("R9 one irq pulse", 64'(d), 64'd1);
      overflow_run(d);
      chk("R9 no irq with flag set", 64'(d), 64'd0);
      csr_rd(A_EVSEL, rd);
      chk("R8 flag stays set", {63'd0, rd[31]}, 64'd1);
      csr_wr(A_EVSEL, 32'd1);
      csr_rd(A_EVSEL, rd);
      chk("R8 flag cleared by write", {63'd0, rd[31]}, 64'd0);
      overflow_run(d);
      chk("R9 irq after clear", 64'(d), 64'd1);
      csr_wr(A_CYCLE_HI, 32'hFFFF_FFFF);
      s1 = 64'(irqn);
      csr_wr(A_CYCLE_LO, 32'hFFFF_FFFE);
      repeat (4) @(negedge clk);
      chk("R9 fixed wrap silent", 64'(irqn), s1);

      // R10 read mux
      csr_rd(12'h123, rd);
      chk("R10 unmapped reads zero", {32'd0, rd}, 64'd0);
      csr_wr(A_EVSEL + 12'd1, 32'hFFFF_FFFF);
      csr_rd(A_EVSEL + 12'd1, rd);
      chk("R10 selector readback", {32'd0, rd}, 64'hF000_00FF);
      csr_rd(A_CYCLE_HI, rd);
      csr_rd(A_CYCLE_LO, rd2);
      chk("R10 cycle halves", {rd, rd2}, cycle_o);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule